// File: doc/BRIEF.md
# Paged Nonvolatile Memory Write-Load Controller

This block is the front end of a byte-wide paged nonvolatile memory that a host drives like an asynchronous static RAM. The active-low chip enable (`ceN`), output enable (`oeN`) and write enable (`weN`) strobes, the 17-bit address and the 8-bit data bus are sampled in a fast system clock. A write cycle is the span in which `ceN` and `weN` are both low. Its address is taken where that span opens and its data where it closes.

Writes are accepted into a one-page buffer only after a three-write unlock sequence. The first accepted byte fixes the page. Later bytes on the same page restart an inter-byte window. When the window runs out, the page goes to a programming stage, which holds `busy` for a fixed number of cycles. At the end of that stage, only the bytes that were loaded are written into a small register-array stub, which stands in for the real array. Reads return stub contents on a data output that has its own drive enable.

Top module: `eeprom_page_loader`

## Requirements
- R1: Two clock cycles after the pins show `ceN`=0, `oeN`=0 and `weN`=1, `dataOe` is 1 and `dataOut` holds the stub byte at the low `STUB_ADDR_W` address bits. The stub is a byte array of 2^`STUB_ADDR_W` entries.
- R2: Whenever `ceN` or `oeN` is high, or `weN` is low, `dataOe` is 0 two cycles later. While `dataOe` is 0, `dataOut` is 0.
- R3: A write's address is the one sampled in the first cycle that `ceN` and `weN` are both low. Address changes later in the same write cycle have no effect. Either strobe may be the one that falls last.
- R4: A write's data is the last value sampled while `ceN` and `weN` are both still low. A data change in the cycle where either strobe rises has no effect.
- R5: Unlocking takes three consecutive writes: address 0x05555 with data 0xAA, then 0x02AAA with 0x55, then 0x05555 with 0xA0. Any other write in the middle of the sequence sends the detector back to its first step. Writes made while locked never reach the stub.
- R6: The first write after unlocking opens a page load. It sets the page to address bits 16..7, and bits 6..0 select the byte. Bytes may arrive in any order, and the load holds from 1 to 128 of them.
- R7: During a load, a write whose bits 16..7 differ from the opened page is ignored and does not restart the window.
- R8: Each accepted byte restarts a window of `WINDOW_CYCLES` cycles. When the window passes with no accepted byte, `busy` rises.
- R9: Rewriting a byte in the same load keeps the last value. At programming, only loaded bytes change, and every other stub byte keeps its contents.
- R10: `busy` stays high for exactly `PROG_CYCLES` cycles. All writes made while it is high, including unlock writes, are ignored. Reads return the pre-programming contents until it falls. Each load consumes the unlock.
- R11: After reset, `busy` and `dataOe` are 0 and every stub byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| addr | input | 17 | Byte address |
| dataIn | input | 8 | Write data bus |
| dataOut | output | 8 | Read data, 0 when not driven |
| dataOe | output | 1 | Drive enable for `dataOut` |
| busy | output | 1 | Programming in progress |

## Verification
The assertions assume that the strobes and buses are already synchronous to `clk` and that each level is held for at least one sampled cycle. They need no other limits on input order, because the read-enable and state-sequencing properties hold for any pin activity. The stimulus drives every pin on the falling clock edge. It holds each write strobe low for three cycles and holds the address and data on purpose across the capture points, so every write is seen exactly once. Programming waits are sized from `WINDOW_CYCLES` and `PROG_CYCLES`, so no unrelated write lands while `busy` is changing state.

// File: rtl/epl_pkg.sv
package epl_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic bufWrite;   // store completed write into page buffer
    logic tagLoad;    // latch page bits of completed write
    logic timerLoad;  // restart inter-byte window
    logic commit;     // copy marked bytes into the array
  } ctrlStrb_t;

  typedef enum logic [1:0] {
    LS_IDLE,
    LS_LOAD,
    LS_PROG
  } loadState_t;

  typedef enum logic [1:0] {
    UL_STEP1,
    UL_STEP2,
    UL_STEP3,
    UL_OPEN
  } unlockState_t;

endpackage

// File: rtl/epl_datapath.sv
module epl_datapath
  import epl_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int PAGE_BITS     = 7,
  parameter int STUB_ADDR_W   = 10,
  parameter int WINDOW_CYCLES = 7500,
  parameter logic [ADDR_W-1:0] CMD_ADDR_A = 17'h05555,
  parameter logic [ADDR_W-1:0] CMD_ADDR_B = 17'h02AAA,
  parameter logic [DATA_W-1:0] CMD_DATA_1 = 8'hAA,
  parameter logic [DATA_W-1:0] CMD_DATA_2 = 8'h55,
  parameter logic [DATA_W-1:0] CMD_DATA_3 = 8'hA0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  ctrlStrb_t         strb,
  output logic              wrEvt,
  output logic [2:0]        cmdHit,
  output logic              pageHit,
  output logic              timerZero,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  localparam int PAGE_SIZE  = 1 << PAGE_BITS;
  localparam int TAG_W      = ADDR_W - PAGE_BITS;
  localparam int TAG_LO_W   = STUB_ADDR_W - PAGE_BITS;
  localparam int STUB_DEPTH = 1 << STUB_ADDR_W;
  localparam int WIN_W      = $clog2(WINDOW_CYCLES + 1);

  // input sampling stage
  logic              ceS, oeS, weS;
  logic [ADDR_W-1:0] addrS;
  logic [DATA_W-1:0] dataS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ceS   <= 1'b1;
      oeS   <= 1'b1;
      weS   <= 1'b1;
      addrS <= '0;
      dataS <= '0;
    end else begin
      ceS   <= ceN;
      oeS   <= oeN;
      weS   <= weN;
      addrS <= addr;
      dataS <= dataIn;
    end
  end

  // combined write strobe and its edges
  logic              strobeNow, strobePrev;
  logic [ADDR_W-1:0] wAddr;
  logic [DATA_W-1:0] wData;

  assign strobeNow = ~ceS & ~weS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobePrev <= 1'b0;
      wAddr      <= '0;
      wData      <= '0;
    end else begin
      strobePrev <= strobeNow;
      if (strobeNow && !strobePrev) wAddr <= addrS;
      if (strobeNow)                wData <= dataS;
    end
  end

  assign wrEvt     = strobePrev & ~strobeNow;
  assign cmdHit[0] = (wAddr == CMD_ADDR_A) && (wData == CMD_DATA_1);
  assign cmdHit[1] = (wAddr == CMD_ADDR_B) && (wData == CMD_DATA_2);
  assign cmdHit[2] = (wAddr == CMD_ADDR_A) && (wData == CMD_DATA_3);

  // page tag
  logic [TAG_W-1:0] pageTag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pageTag <= '0;
    else if (strb.tagLoad) pageTag <= wAddr[ADDR_W-1:PAGE_BITS];
  end

  assign pageHit = (wAddr[ADDR_W-1:PAGE_BITS] == pageTag);

  // page buffer and valid mask
  logic [DATA_W-1:0]    pageBuf [PAGE_SIZE];
  logic [PAGE_SIZE-1:0] validMask;

  always_ff @(posedge clk) begin
    if (strb.bufWrite) pageBuf[wAddr[PAGE_BITS-1:0]] <= wData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                validMask <= '0;
    else if (strb.commit)      validMask <= '0;
    else if (strb.bufWrite)    validMask[wAddr[PAGE_BITS-1:0]] <= 1'b1;
  end

  // inter-byte window
  logic [WIN_W-1:0] winCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              winCnt <= '0;
    else if (strb.timerLoad) winCnt <= WIN_W'(WINDOW_CYCLES - 1);
    else if (winCnt != '0)   winCnt <= winCnt - 1'b1;
  end

  assign timerZero = (winCnt == '0);

  // array stub
  logic [DATA_W-1:0] mem [STUB_DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < STUB_DEPTH; j++) mem[j] <= '1;
    end else if (strb.commit) begin
      for (int i = 0; i < PAGE_SIZE; i++) begin
        if (validMask[i]) mem[{pageTag[TAG_LO_W-1:0], PAGE_BITS'(i)}] <= pageBuf[i];
      end
    end
  end

  // read path
  logic readEn;
  assign readEn = ~ceS & ~oeS & weS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataOut <= '0;
      dataOe  <= 1'b0;
    end else begin
      dataOe  <= readEn;
      dataOut <= readEn ? mem[addrS[STUB_ADDR_W-1:0]] : '0;
    end
  end

endmodule

// File: rtl/epl_control.sv
module epl_control
  import epl_pkg::*;
#(
  parameter int PROG_CYCLES = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrEvt,
  input  logic [2:0] cmdHit,
  input  logic       pageHit,
  input  logic       timerZero,
  output ctrlStrb_t  strb,
  output logic       busy
);

  localparam int PROG_W = $clog2(PROG_CYCLES + 1);

  loadState_t   loadState, loadNext;
  unlockState_t ulState, ulNext;
  logic [PROG_W-1:0] progCnt;

  always_comb begin
    strb     = '0;
    loadNext = loadState;
    ulNext   = ulState;
    unique case (loadState)
      LS_IDLE: begin
        if (wrEvt) begin
          if (ulState == UL_OPEN) begin
            strb.bufWrite  = 1'b1;
            strb.tagLoad   = 1'b1;
            strb.timerLoad = 1'b1;
            loadNext       = LS_LOAD;
            ulNext         = UL_STEP1;
          end else begin
            unique case (ulState)
              UL_STEP1: ulNext = cmdHit[0] ? UL_STEP2 : UL_STEP1;
              UL_STEP2: ulNext = cmdHit[1] ? UL_STEP3 : UL_STEP1;
              UL_STEP3: ulNext = cmdHit[2] ? UL_OPEN  : UL_STEP1;
              default:  ulNext = UL_STEP1;
            endcase
          end
        end
      end
      LS_LOAD: begin
        if (wrEvt && pageHit) begin
          strb.bufWrite  = 1'b1;
          strb.timerLoad = 1'b1;
        end else if (timerZero) begin
          loadNext = LS_PROG;
        end
      end
      LS_PROG: begin
        if (progCnt == '0) begin
          strb.commit = 1'b1;
          loadNext    = LS_IDLE;
        end
      end
      default: loadNext = LS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loadState <= LS_IDLE;
      ulState   <= UL_STEP1;
      progCnt   <= '0;
    end else begin
      loadState <= loadNext;
      ulState   <= ulNext;
      if (loadState != LS_PROG && loadNext == LS_PROG)
        progCnt <= PROG_W'(PROG_CYCLES - 1);
      else if (progCnt != '0)
        progCnt <= progCnt - 1'b1;
    end
  end

  assign busy = (loadState == LS_PROG);

endmodule

// File: rtl/eeprom_page_loader.sv
module eeprom_page_loader
  import epl_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int PAGE_BITS     = 7,
  parameter int STUB_ADDR_W   = 10,
  parameter int WINDOW_CYCLES = 7500,
  parameter int PROG_CYCLES   = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              busy
);

  ctrlStrb_t  strb;
  logic       wrEvt;
  logic [2:0] cmdHit;
  logic       pageHit;
  logic       timerZero;

  epl_datapath #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .PAGE_BITS     (PAGE_BITS),
    .STUB_ADDR_W   (STUB_ADDR_W),
    .WINDOW_CYCLES (WINDOW_CYCLES)
  ) u_datapath (
    .clk       (clk),
    .rst_n     (rst_n),
    .ceN       (ceN),
    .oeN       (oeN),
    .weN       (weN),
    .addr      (addr),
    .dataIn    (dataIn),
    .strb      (strb),
    .wrEvt     (wrEvt),
    .cmdHit    (cmdHit),
    .pageHit   (pageHit),
    .timerZero (timerZero),
    .dataOut   (dataOut),
    .dataOe    (dataOe)
  );

  epl_control #(
    .PROG_CYCLES (PROG_CYCLES)
  ) u_control (
    .clk       (clk),
    .rst_n     (rst_n),
    .wrEvt     (wrEvt),
    .cmdHit    (cmdHit),
    .pageHit   (pageHit),
    .timerZero (timerZero),
    .strb      (strb),
    .busy      (busy)
  );

endmodule

// File: rtl/epl_checker.sv
module epl_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ceN,
  input logic              oeN,
  input logic              weN,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOe,
  input logic              busy,
  input logic              bufWrite,
  input logic              commit,
  input logic              timerZero
);

  // R1: drive enable only follows a read condition on the pins two cycles earlier
  p_read_enable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dataOe |-> $past(!ceN && !oeN && weN, 2));

  // R2: undriven output is zero
  p_out_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dataOe |-> (dataOut == '0));

  // R8: programming only starts when the window has run out
  p_busy_on_expiry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(timerZero));

  // R10: no byte enters the buffer while programming
  p_no_load_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bufWrite |-> !busy);

  // R10: commit is the last programming cycle
  p_commit_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy);

endmodule

bind eeprom_page_loader epl_checker #(.DATA_W(DATA_W)) u_eplChecker (
  .clk       (clk),
  .rst_n     (rst_n),
  .ceN       (ceN),
  .oeN       (oeN),
  .weN       (weN),
  .dataOut   (dataOut),
  .dataOe    (dataOe),
  .busy      (busy),
  .bufWrite  (strb.bufWrite),
  .commit    (strb.commit),
  .timerZero (timerZero)
);

// File: tb/test_eeprom_page_loader.sv
module test_eeprom_page_loader;

  localparam int WIN   = 40;
  localparam int PROG  = 60;
  localparam int SAW   = 9;
  localparam int DEPTH = 1 << SAW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic [16:0] addr = '0;
  logic [7:0]  dataIn = '0;
  logic [7:0]  dataOut;
  logic        dataOe;
  logic        busy;

  always #10 clk = ~clk;

  eeprom_page_loader #(
    .WINDOW_CYCLES (WIN),
    .PROG_CYCLES   (PROG),
    .STUB_ADDR_W   (SAW)
  ) i_eeprom_page_loader (
    .clk     (clk),
    .rst_n   (rst_n),
    .ceN     (ceN),
    .oeN     (oeN),
    .weN     (weN),
    .addr    (addr),
    .dataIn  (dataIn),
    .dataOut (dataOut),
    .dataOe  (dataOe),
    .busy    (busy)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;
  logic [7:0] refMem [DEPTH];

  // busy pulse length monitor
  int busyRun = 0;
  int lastBusyLen = 0;
  always @(posedge clk) begin
    if (busy) busyRun <= busyRun + 1;
    else if (busyRun != 0) begin
      lastBusyLen <= busyRun;
      busyRun <= 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [16:0] a, input logic [7:0] d, input bit ceLast);
    @(negedge clk); ceN = 1'b1; oeN = 1'b1; weN = 1'b1;
    @(negedge clk); addr = a; dataIn = ~d;
    if (ceLast) weN = 1'b0; else ceN = 1'b0;
    @(negedge clk); if (ceLast) ceN = 1'b0; else weN = 1'b0;
    @(negedge clk); addr = a ^ 17'h01555;          // R3: late address change
    @(negedge clk); dataIn = d;                    // R4: final data
    @(negedge clk); dataIn = d ^ 8'h3C;            // R4: change at release
    if (ceLast) ceN = 1'b1; else weN = 1'b1;
    @(negedge clk); ceN = 1'b1; weN = 1'b1; addr = ~a;
  endtask

  task automatic unlock();
    busWrite(17'h05555, 8'hAA, 1'b0);
    busWrite(17'h02AAA, 8'h55, 1'b1);
    busWrite(17'h05555, 8'hA0, 1'b0);
  endtask

  task automatic readByte(input logic [16:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk); ceN = 1'b0; oeN = 1'b0; weN = 1'b1; addr = a;
    repeat (3) @(negedge clk);
    d = dataOut; oe = dataOe;
  endtask

  task automatic idleBus();
    @(negedge clk); ceN = 1'b1; oeN = 1'b1; weN = 1'b1;
  endtask

  task automatic checkAll(input string req);
    logic [7:0] d;
    logic oe;
    for (int a = 0; a < DEPTH; a++) begin
      readByte(17'(a), d, oe);
      check(oe === 1'b1 && d === refMem[a], req, {oe, d}, {1'b1, refMem[a]});
    end
    idleBus();
  endtask

  task automatic waitIdle();
    for (int k = 0; k < 1000 && busy; k++) @(negedge clk);
  endtask

  function automatic logic [16:0] pa(input int page, input int idx);
    return 17'((page << 7) | idx);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic oe;
    for (int a = 0; a < DEPTH; a++) refMem[a] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset state
    check(busy === 1'b0, "R11", busy, 0);
    check(dataOe === 1'b0, "R11", dataOe, 0);
    readByte(pa(0, 0), d, oe);
    check(d === 8'hFF && oe, "R11", d, 8'hFF);
    readByte(pa(3, 127), d, oe);
    check(d === 8'hFF && oe, "R11", d, 8'hFF);

    // R1 / R2: drive enable conditions
    @(negedge clk); ceN = 1'b0; oeN = 1'b1; weN = 1'b1; waitCycles(3);
    check(dataOe === 1'b0 && dataOut === 8'h00, "R2", {dataOe, dataOut}, 0);
    @(negedge clk); ceN = 1'b1; oeN = 1'b0; waitCycles(3);
    check(dataOe === 1'b0 && dataOut === 8'h00, "R2", {dataOe, dataOut}, 0);
    @(negedge clk); ceN = 1'b0; oeN = 1'b0; weN = 1'b0; waitCycles(3);
    check(dataOe === 1'b0 && dataOut === 8'h00, "R2", {dataOe, dataOut}, 0);
    @(negedge clk); weN = 1'b1; waitCycles(3);
    check(dataOe === 1'b1 && dataOut === 8'hFF, "R1", {dataOe, dataOut}, 9'h1FF);
    idleBus();

    // R5: locked write is ignored
    busWrite(pa(0, 16), 8'h12, 1'b0);
    waitCycles(WIN + 10);
    check(busy === 1'b0, "R5", busy, 0);

    // R5: broken sequences do not unlock
    busWrite(17'h05555, 8'hAA, 1'b0);
    busWrite(17'h02AAA, 8'h55, 1'b0);
    busWrite(17'h05555, 8'hA1, 1'b0);
    busWrite(pa(0, 32), 8'h34, 1'b1);
    busWrite(17'h05555, 8'hAA, 1'b0);
    busWrite(17'h02AAA, 8'h56, 1'b0);
    busWrite(17'h02AAA, 8'h55, 1'b0);
    busWrite(17'h05555, 8'hA0, 1'b0);
    busWrite(pa(0, 33), 8'h35, 1'b1);
    waitCycles(WIN + 10);
    check(busy === 1'b0, "R5", busy, 0);
    readByte(pa(0, 32), d, oe);
    check(d === 8'hFF, "R5", d, 8'hFF);
    readByte(pa(0, 33), d, oe);
    check(d === 8'hFF, "R5", d, 8'hFF);
    idleBus();

    // R6 / R9 / R3 / R4: full page in scrambled order, then overwrites
    unlock();
    for (int k = 0; k < 128; k++) begin
      int i;
      i = (k * 37) % 128;
      busWrite(pa(1, i), 8'((i * 13 + 5) & 8'hFF), k[0]);
      refMem[pa(1, i)] = 8'((i * 13 + 5) & 8'hFF);
    end
    for (int i = 0; i < 16; i++) begin
      busWrite(pa(1, i * 8), 8'(i ^ 8'hC3), i[0]);
      refMem[pa(1, i * 8)] = 8'(i ^ 8'hC3);
    end
    check(busy === 1'b0, "R8", busy, 0);
    waitCycles(WIN + 6);
    check(busy === 1'b1, "R8", busy, 1);
    // R10: reads during programming see old contents
    readByte(pa(1, 3), d, oe);
    check(d === 8'hFF, "R10", d, 8'hFF);
    idleBus();
    // R10: unlock attempted while busy
    unlock();
    check(busy === 1'b1, "R10", busy, 1);
    waitIdle();
    busWrite(pa(2, 0), 8'h11, 1'b0);
    waitCycles(WIN + 10);
    check(busy === 1'b0, "R10", busy, 0);
    check(lastBusyLen == PROG, "R10", lastBusyLen, PROG);
    checkAll("R9");

    // R7 / R9: partial load, repeat write, off-page writes
    unlock();
    busWrite(pa(2, 100), 8'h21, 1'b0);
    busWrite(pa(2, 5),   8'h22, 1'b1);
    busWrite(pa(2, 100), 8'h23, 1'b0);
    busWrite(pa(2, 64),  8'h24, 1'b1);
    refMem[pa(2, 100)] = 8'h23;
    refMem[pa(2, 5)]   = 8'h22;
    refMem[pa(2, 64)]  = 8'h24;
    for (int i = 0; i < 7; i++) busWrite(pa(3, i), 8'h99, 1'b0);
    check(busy === 1'b1, "R7", busy, 1);
    waitIdle();

    // R6: single-byte load at the top of a page
    unlock();
    busWrite(pa(0, 127), 8'h7E, 1'b1);
    refMem[pa(0, 127)] = 8'h7E;
    waitCycles(WIN + 6);
    check(busy === 1'b1, "R6", busy, 1);
    waitIdle();
    checkAll("R7");

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule